// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides a fast input clock by a programmable ratio N using the pulse-swallow method. A dual-modulus prescaler, modelled here in logic and clocked by the input clock itself, divides by either P+1 or P. A main counter counts completed prescaler cycles. A swallow counter keeps the prescaler on its longer modulus for the first A of those cycles. Each complete output cycle therefore lasts N = M·P + A input cycles and ends with a single-cycle output pulse.

A mode bit selects P = 16 (the 16/17 pair) or P = 8 (the 8/9 pair). The mode changes how the swallow field is read and which ratios are allowed. The divider word is offered on plain input ports. It is checked for legality at all times. It is taken into use only at the clock edge that closes an output cycle, so a word change never produces a shortened or stretched output cycle. An illegal word is never taken into use.

Top module: `dms_divider`

## Requirements
- R1: While reset is low, div_out and mod_hi are low. After reset the active word is M=16, A=0, 16/17 mode, so the first div_out pulse comes in the 256th cycle after reset is released.
- R2: With word_lo=0 (16/17 mode, P=16), consecutive div_out pulses are exactly M·16 + A input cycles apart.
- R3: With word_lo=1 (8/9 mode, P=8), consecutive div_out pulses are exactly M·8 + A input cycles apart.
- R4: div_out is high for exactly one input cycle per output cycle, in the last cycle of that output cycle.
- R5: mod_hi is high during the first A·(P+1) input cycles of each output cycle and low for the rest of it. This holds also when A equals M.
- R6: The word inputs are sampled only at the clock edge that ends a cycle in which div_out is high. Changes at any other time do not affect the output cycle in progress.
- R7: word_legal is combinational and is 1 exactly when the effective A is not greater than M and N is at least 256 (16/17 mode) or at least 56 (8/9 mode).
- R8: A word for which word_legal is 0 at the end of an output cycle is not loaded. The previous ratio repeats.
- R9: In 8/9 mode only bits [2:0] of word_a form A, and bit 3 is ignored. In 16/17 mode all four bits are used.
- R10: The largest words (M=32767, A=15) are legal in both modes, giving N=524287 in 16/17 mode and N=262143 in 8/9 mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| word_m | input | 15 | Main count M |
| word_a | input | 4 | Swallow count A (bit 3 ignored in 8/9 mode) |
| word_lo | input | 1 | Modulus mode: 0 = 16/17, 1 = 8/9 |
| word_legal | output | 1 | Presented word is within the legal ratio range |
| div_out | output | 1 | One-cycle pulse closing each output cycle |
| mod_hi | output | 1 | Prescaler modulus control: 1 = P+1, 0 = P |

## Verification
div_out and mod_hi are decoded from registers only. Their value for a given input cycle is therefore settled once the rising edge that starts that cycle has passed, and the bench compares both against its model at every falling edge. word_legal responds to the word inputs in the same cycle, so the bench checks it one time step after driving a word, before the next rising edge. A new word shows its effect only in the output cycle after the pulse whose closing edge loaded it. The bench measures that period from one pulse to the next, and changes words only away from pulse cycles unless it means to hit one.

// File: rtl/dms_pkg.sv
package dms_pkg;

  // Prescaler base modulus P for the selected mode.
  function automatic int base_mod(input logic lo, input int p_hi, input int p_lo);
    return lo ? p_lo : p_hi;
  endfunction

  // Swallow count as the selected mode reads the field.
  function automatic int eff_swallow(input int a, input logic lo, input int p_hi, input int p_lo);
    return a % base_mod(lo, p_hi, p_lo);
  endfunction

  // Total division ratio N = M*P + A.
  function automatic int total_ratio(input int m, input int a, input logic lo,
                                     input int p_hi, input int p_lo);
    return m * base_mod(lo, p_hi, p_lo) + eff_swallow(a, lo, p_hi, p_lo);
  endfunction

  // Legality: swallow count within main count and ratio above the mode floor.
  function automatic logic word_ok(input int m, input int a, input logic lo,
                                   input int p_hi, input int p_lo,
                                   input int nmin_hi, input int nmin_lo);
    int floor_n;
    floor_n = lo ? nmin_lo : nmin_hi;
    return (eff_swallow(a, lo, p_hi, p_lo) <= m) &&
           (total_ratio(m, a, lo, p_hi, p_lo) >= floor_n);
  endfunction

endpackage

// File: rtl/dms_word_gate.sv
module dms_word_gate #(
  parameter int M_W      = 15,
  parameter int A_W      = 4,
  parameter int P_HI     = 16,
  parameter int P_LO     = 8,
  parameter int NMIN_HI  = 256,
  parameter int NMIN_LO  = 56,
  parameter int RST_M    = 16,
  parameter int RST_A    = 0,
  parameter bit RST_LO   = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] in_m,
  input  logic [A_W-1:0] in_a,
  input  logic           in_lo,
  input  logic           end_evt,
  output logic           legal,
  output logic [M_W-1:0] act_m,
  output logic [A_W-1:0] act_a,
  output logic           act_lo,
  output logic [M_W-1:0] nxt_m,
  output logic [A_W-1:0] nxt_a,
  output logic           nxt_lo
);
  logic [A_W-1:0] in_a_eff;
  logic           act_ok;

  assign legal    = dms_pkg::word_ok(int'(in_m), int'(in_a), in_lo,
                                     P_HI, P_LO, NMIN_HI, NMIN_LO);
  assign in_a_eff = A_W'(dms_pkg::eff_swallow(int'(in_a), in_lo, P_HI, P_LO));

  // Word to be used from the next output cycle on.
  always_comb begin
    if (legal) begin
      nxt_m  = in_m;
      nxt_a  = in_a_eff;
      nxt_lo = in_lo;
    end else begin
      nxt_m  = act_m;
      nxt_a  = act_a;
      nxt_lo = act_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_m  <= M_W'(RST_M);
      act_a  <= A_W'(RST_A);
      act_lo <= RST_LO;
    end else if (end_evt) begin
      act_m  <= nxt_m;
      act_a  <= nxt_a;
      act_lo <= nxt_lo;
    end
  end

  assign act_ok = dms_pkg::word_ok(int'(act_m), int'(act_a), act_lo,
                                   P_HI, P_LO, NMIN_HI, NMIN_LO);

  // R6
  word_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_m, act_a, act_lo}) |-> $past(end_evt));

  // R8
  active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) act_ok);

endmodule

// File: rtl/dms_prescaler.sv
module dms_prescaler #(
  parameter int P_HI   = 16,
  parameter int P_LO   = 8,
  parameter int PC_W   = 5,
  parameter bit RST_LO = 1'b0,
  parameter bit RST_HI = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_lo,
  input  logic reload_hi,
  output logic tick
);
  logic [PC_W-1:0] pre_cnt;

  // Down-count start value for a prescaler cycle of P or P+1 input cycles.
  function automatic logic [PC_W-1:0] span(input logic lo, input logic hi);
    return PC_W'(dms_pkg::base_mod(lo, P_HI, P_LO) + (hi ? 1 : 0) - 1);
  endfunction

  assign tick = (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_cnt <= span(RST_LO, RST_HI);
    else if (tick)
      pre_cnt <= span(reload_lo, reload_hi);
    else
      pre_cnt <= pre_cnt - 1'b1;
  end

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_cnt) <= P_HI);

endmodule

// File: rtl/dms_swallow_ctr.sv
module dms_swallow_ctr #(
  parameter int M_W   = 15,
  parameter int A_W   = 4,
  parameter int RST_M = 16,
  parameter int RST_A = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           act_lo,
  input  logic [M_W-1:0] nxt_m,
  input  logic [A_W-1:0] nxt_a,
  input  logic           nxt_lo,
  output logic           end_evt,
  output logic           mod_hi,
  output logic           reload_lo,
  output logic           reload_hi
);
  logic [M_W-1:0] m_cnt;
  logic [A_W-1:0] a_cnt;

  assign end_evt = tick && (m_cnt == M_W'(1));
  assign mod_hi  = (a_cnt != '0);

  // Modulus of the prescaler cycle that starts after this edge.
  always_comb begin
    if (end_evt) begin
      reload_hi = (nxt_a != '0);
      reload_lo = nxt_lo;
    end else begin
      reload_hi = (a_cnt > A_W'(1));
      reload_lo = act_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= M_W'(RST_M);
      a_cnt <= A_W'(RST_A);
    end else if (end_evt) begin
      m_cnt <= nxt_m;
      a_cnt <= nxt_a;
    end else if (tick) begin
      m_cnt <= m_cnt - 1'b1;
      if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
    end
  end

  // R5
  swallow_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> (a_cnt == '0) || (a_cnt == A_W'(1) && m_cnt == M_W'(1)));

  // R4
  main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_cnt != '0);

endmodule

// File: rtl/dms_divider.sv
module dms_divider #(
  parameter int M_W     = 15,
  parameter int A_W     = 4,
  parameter int P_HI    = 16,
  parameter int P_LO    = 8,
  parameter int NMIN_HI = 256,
  parameter int NMIN_LO = 56,
  parameter int RST_M   = 16,
  parameter int RST_A   = 0,
  parameter bit RST_LO  = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] word_m,
  input  logic [A_W-1:0] word_a,
  input  logic           word_lo,
  output logic           word_legal,
  output logic           div_out,
  output logic           mod_hi
);
  localparam int PC_W      = $clog2(P_HI + 2);
  localparam int RST_A_EFF = dms_pkg::eff_swallow(RST_A, RST_LO, P_HI, P_LO);
  localparam bit RST_HI    = (RST_A_EFF != 0);

  logic           tick, end_evt, reload_lo, reload_hi;
  logic [M_W-1:0] act_m, nxt_m;
  logic [A_W-1:0] act_a, nxt_a;
  logic           act_lo, nxt_lo;

  dms_word_gate #(
    .M_W(M_W), .A_W(A_W), .P_HI(P_HI), .P_LO(P_LO),
    .NMIN_HI(NMIN_HI), .NMIN_LO(NMIN_LO),
    .RST_M(RST_M), .RST_A(RST_A_EFF), .RST_LO(RST_LO)
  ) u_gate (
    .clk(clk), .rst_n(rst_n),
    .in_m(word_m), .in_a(word_a), .in_lo(word_lo),
    .end_evt(end_evt), .legal(word_legal),
    .act_m(act_m), .act_a(act_a), .act_lo(act_lo),
    .nxt_m(nxt_m), .nxt_a(nxt_a), .nxt_lo(nxt_lo)
  );

  dms_swallow_ctr #(
    .M_W(M_W), .A_W(A_W), .RST_M(RST_M), .RST_A(RST_A_EFF)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act_lo(act_lo),
    .nxt_m(nxt_m), .nxt_a(nxt_a), .nxt_lo(nxt_lo),
    .end_evt(end_evt), .mod_hi(mod_hi),
    .reload_lo(reload_lo), .reload_hi(reload_hi)
  );

  dms_prescaler #(
    .P_HI(P_HI), .P_LO(P_LO), .PC_W(PC_W), .RST_LO(RST_LO), .RST_HI(RST_HI)
  ) u_pre (
    .clk(clk), .rst_n(rst_n),
    .reload_lo(reload_lo), .reload_hi(reload_hi), .tick(tick)
  );

  assign div_out = end_evt;

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R5
  mod_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(tick));

endmodule

// File: tb/dms_divider_tb.sv
module dms_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] word_m = 15'd16;
  logic [3:0]  word_a = 4'd0;
  logic        word_lo = 1'b0;
  logic        word_legal, div_out, mod_hi;

  int checks = 0, fails = 0;
  int rem, cur_n, cur_a, cur_p;
  int since = 1, last_gap = 0, pulses = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dms_divider u_dut (
    .clk(clk), .rst_n(rst_n), .word_m(word_m), .word_a(word_a),
    .word_lo(word_lo), .word_legal(word_legal), .div_out(div_out), .mod_hi(mod_hi)
  );

  function automatic bit ref_legal(int m, int a, bit lo);
    int p, ae;
    p  = lo ? 8 : 16;
    ae = lo ? (a & 7) : a;
    return (ae <= m) && (m * p + ae >= (lo ? 56 : 256));
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Behavioural model: remaining cycles of the current output cycle.
  always @(posedge clk) begin
    if (!rst_n) begin
      cur_p = 16; cur_a = 0; cur_n = 256; rem = 256;
    end else if (rem == 1) begin
      if (ref_legal(int'(word_m), int'(word_a), word_lo)) begin
        cur_p = word_lo ? 8 : 16;
        cur_a = word_lo ? (int'(word_a) & 7) : int'(word_a);
        cur_n = int'(word_m) * cur_p + cur_a;
      end
      rem = cur_n;
    end else begin
      rem = rem - 1;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_pulse, exp_mod;
      int pos;
      pos       = cur_n - rem;
      exp_pulse = (rem == 1);
      exp_mod   = (pos < cur_a * (cur_p + 1));
      // R2 R3 R4: pulse position within the output cycle
      check(div_out == exp_pulse, (cur_p == 16) ? "R2" : "R3", "div_out",
            int'(div_out), int'(exp_pulse));
      // R5: modulus control phase
      check(mod_hi == exp_mod, "R5", "mod_hi", int'(mod_hi), int'(exp_mod));
      if (div_out) begin
        last_gap = since;
        since = 1;
        pulses++;
      end else begin
        since++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic wait_pulses(int n);
    int target;
    target = pulses + n;
    while (pulses < target) @(negedge clk);
    #1;
  endtask

  task automatic apply(int m, int a, bit lo);
    @(negedge clk);
    while (div_out) @(negedge clk);
    word_m = 15'(m); word_a = 4'(a); word_lo = lo;
  endtask

  task automatic probe(int m, int a, bit lo, bit exp, string req);
    @(negedge clk);
    while (div_out) @(negedge clk);
    word_m = 15'(m); word_a = 4'(a); word_lo = lo;
    #1;
    check(word_legal == exp, req, "word_legal", int'(word_legal), int'(exp));
    check(word_legal == ref_legal(m, a, lo), req, "word_legal vs rule",
          int'(word_legal), int'(ref_legal(m, a, lo)));
    word_m = 15'd16; word_a = 4'd0; word_lo = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(div_out == 1'b0, "R1", "div_out in reset", int'(div_out), 0);
    check(mod_hi == 1'b0, "R1", "mod_hi in reset", int'(mod_hi), 0);
    rst_n = 1'b1;
    wait_pulses(1);
    check(last_gap == 256, "R1", "first period", last_gap, 256);

    // R7 floors and swallow limit, R9 field width, R10 largest words
    probe(15, 15, 1'b0, 1'b0, "R7");
    probe(16, 0, 1'b0, 1'b1, "R7");
    probe(7, 0, 1'b1, 1'b1, "R7");
    probe(6, 6, 1'b1, 1'b0, "R7");
    probe(7, 15, 1'b1, 1'b1, "R9");
    probe(6, 15, 1'b1, 1'b0, "R9");
    probe(32767, 15, 1'b0, 1'b1, "R10");
    probe(32767, 15, 1'b1, 1'b1, "R10");

    apply(20, 5, 1'b0);  wait_pulses(2);
    check(last_gap == 325, "R2", "period 20/5", last_gap, 325);
    apply(16, 15, 1'b0); wait_pulses(2);
    check(last_gap == 271, "R2", "period 16/15", last_gap, 271);
    apply(7, 3, 1'b1);   wait_pulses(2);
    check(last_gap == 59, "R3", "period 7/3", last_gap, 59);
    apply(7, 7, 1'b1);   wait_pulses(2);
    check(last_gap == 63, "R5", "period A equals M", last_gap, 63);
    apply(9, 13, 1'b1);  wait_pulses(2);
    check(last_gap == 77, "R9", "period with A bit 3 set", last_gap, 77);

    apply(6, 6, 1'b1);
    #1;
    check(word_legal == 1'b0, "R8", "illegal word flagged", int'(word_legal), 0);
    wait_pulses(2);
    check(last_gap == 77, "R8", "illegal word not loaded", last_gap, 77);

    // R6: mid-cycle word changes
    word_m = 15'd9; word_a = 4'd13; word_lo = 1'b1;
    wait_pulses(1);
    apply(8, 0, 1'b1);
    repeat (10) @(negedge clk);
    word_m = 15'd10; word_a = 4'd2; word_lo = 1'b1;
    wait_pulses(1);
    check(last_gap == 77, "R6", "cycle in progress untouched", last_gap, 77);
    wait_pulses(1);
    check(last_gap == 82, "R6", "last word before end wins", last_gap, 82);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule